// File: doc/BRIEF.md
# Fast Interrupt Request Controller

This block drives the processor's fast interrupt request line from a single external source. The raw input is first brought into the clock domain. It is then qualified by a programmable trigger type: rising edge, falling edge, high level or low level. The result is gated by an enable bit. In the edge modes a detected edge is held in a sticky pending flag. In the level modes the request simply follows the synchronized input.

Software sees the block through a small synchronous register bus. It selects the trigger type, loads a handler address, and enables or disables the request with set/clear command writes. The handler address can be read back through a second location, the fast vector location, so that a single load can branch to the service routine. That read also clears a pending edge request. It has no effect in the level modes. A three-bit priority field is kept only for software: it reads back as written and changes nothing.

Top module: `fiq_ctrl`

## Requirements
- R1: After reset, `fiq_req` is 0, the enable bit is 0, and the mode word, vector word and mask word all read as 0.
- R2: The mode word at 0x000 keeps the trigger type in bits [6:5] and the priority field in bits [2:0]. All other bits read back as 0. The priority value has no effect on the request or on its latency.
- R3: A word written at 0x080 reads back unchanged at 0x080 and at the fast vector location 0x104.
- R4: Writing bit 0 = 1 at 0x120 sets the enable bit, and writing bit 0 = 1 at 0x124 clears it. A write with bit 0 = 0 to either location changes nothing. Bit 0 of the word at 0x110 shows the enable bit.
- R5: Reads at 0x120 and 0x124 return 0.
- R6: With trigger type 2'b11 (rising edge), a 0-to-1 change on `src_in` raises `fiq_req` on the fourth rising clock edge after the change. The request then stays high after the input returns low.
- R7: With trigger type 2'b01 (falling edge), a 1-to-0 change raises `fiq_req` on the fourth clock edge. A 0-to-1 change raises nothing.
- R8: With trigger type 2'b10 (high level), `fiq_req` follows `src_in` with a three-edge latency in both directions.
- R9: With trigger type 2'b00 (low level), `fiq_req` follows the inverse of `src_in` with a three-edge latency.
- R10: In an edge mode, a read at 0x104 clears the pending request, and `fiq_req` falls one edge after the read edge. In a level mode, the same read leaves `fiq_req` unchanged.
- R11: `fiq_req` is low whenever the enable bit was low on the preceding edge. Disabling does not discard a pending edge, so re-enabling raises the request again one edge after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| src_in | input | 1 | Raw asynchronous interrupt source |
| fiq_req | output | 1 | Registered fast interrupt request, active high |

## Verification
Several rules are checked on every cycle:
- the enable and disable commands take effect on the next edge;
- the command locations read as zero;
- the request never rises while the enable bit was low;
- a fast-vector read with no competing edge always empties the pending flag.

Other behaviour can only be shown by the bench's scenarios:
- the exact three- and four-edge latencies for each trigger type;
- the stickiness of an edge request after the input returns;
- the retention of a pending edge across disable and enable;
- the fact that neither the priority field nor a vector read in a level mode changes the output.

// File: rtl/fiq_pkg.sv
// fiq_pkg: shared types and register layout for the fast interrupt controller.
// Assumes byte offsets fit in the bus address width chosen by the top.
package fiq_pkg;

    // Trigger type: bit 0 selects edge mode, bit 1 selects the active polarity
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    localparam int unsigned OFS_MODE = 'h000;
    localparam int unsigned OFS_VEC  = 'h080;
    localparam int unsigned OFS_FVR  = 'h104;
    localparam int unsigned OFS_MASK = 'h110;
    localparam int unsigned OFS_EN   = 'h120;
    localparam int unsigned OFS_DIS  = 'h124;

    localparam int unsigned TRIG_LSB = 5;
    localparam int unsigned PRIO_W   = 3;

endpackage

// File: rtl/fiq_sync.sv
// fiq_sync: a chain of STAGES flops that brings an asynchronous bit into clk.
// Assumes STAGES >= 1; the reset value of every stage is 0.
module fiq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the input through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fiq_detect.sv
// fiq_detect: turns the synchronized source into an active request according to
// the trigger type. Edge modes latch a sticky pending flag that a vector read
// clears, and a new edge in the same cycle wins over the clear. Level modes pass
// the polarity-matched level and hold pending at 0.
module fiq_detect
    import fiq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl,
    input  trig_e trig,
    input  logic  clr,
    output logic  active
);

    logic prev_lvl;
    logic pending;
    logic edge_mode;
    logic hit;

    assign edge_mode = trig[0];
    assign hit       = trig[1] ? (lvl & ~prev_lvl) : (~lvl & prev_lvl);

    // Track the last level and maintain the sticky edge flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
            pending  <= 1'b0;
        end else begin
            prev_lvl <= lvl;
            if (!edge_mode)  pending <= 1'b0;
            else if (hit)    pending <= 1'b1;
            else if (clr)    pending <= 1'b0;
        end
    end

    // Select the request source for the current mode
    always_comb begin
        if (edge_mode) active = pending;
        else           active = (lvl == trig[1]);
    end

    // R10
    vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr && !hit) |=> !pending);

    // R6
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && hit && $stable(trig)) |=> active);

endmodule

// File: rtl/fiq_ctrl.sv
// fiq_ctrl: register front end and output stage of the fast interrupt controller.
// Assumes single-cycle read and write strobes. Read data is registered and is
// valid one cycle after the strobe. The request output is registered.
module fiq_ctrl
    import fiq_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              src_in,
    output logic              fiq_req
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);
    localparam logic [ADDR_W-1:0] A_FVR  = ADDR_W'(OFS_FVR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);

    trig_e              trig_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [DATA_W-1:0]  vec_q;
    logic               en_q;
    logic               src_sync;
    logic               active;
    logic               vec_rd;
    logic [DATA_W-1:0]  mode_word;
    logic [DATA_W-1:0]  rd_mux;

    assign vec_rd = bus_rd && (bus_addr == A_FVR);

    fiq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_in),
        .q     (src_sync)
    );

    fiq_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (src_sync),
        .trig   (trig_q),
        .clr    (vec_rd),
        .active (active)
    );

    // Apply software writes to the mode, vector and enable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= TRIG_LOW;
            prio_q <= '0;
            vec_q  <= '0;
            en_q   <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MODE: begin
                    trig_q <= trig_e'(bus_wdata[TRIG_LSB +: 2]);
                    prio_q <= bus_wdata[PRIO_W-1:0];
                end
                A_VEC:  vec_q <= bus_wdata;
                A_EN:   if (bus_wdata[0]) en_q <= 1'b1;
                A_DIS:  if (bus_wdata[0]) en_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Assemble the mode word from its two fields
    always_comb begin
        mode_word                  = '0;
        mode_word[TRIG_LSB +: 2]   = trig_q;
        mode_word[PRIO_W-1:0]      = prio_q;
    end

    // Select the read value by address
    always_comb begin
        case (bus_addr)
            A_MODE:         rd_mux = mode_word;
            A_VEC, A_FVR:   rd_mux = vec_q;
            A_MASK:         rd_mux = DATA_W'(en_q);
            default:        rd_mux = '0;
        endcase
    end

    // Register read data on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // Register the masked request
    always_ff @(posedge clk) begin
        if (!rst_n) fiq_req <= 1'b0;
        else        fiq_req <= active & en_q;
    end

    // R4
    en_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN && bus_wdata[0]) |=> en_q);

    // R4
    dis_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIS && bus_wdata[0]) |=> !en_q);

    // R5
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_EN || bus_addr == A_DIS)) |=> (bus_rdata == '0));

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !fiq_req);

endmodule

// File: tb/fiq_ctrl_test.sv
// fiq_ctrl_test: scoreboard bench. Read tasks queue expected words, and a
// negedge monitor compares them with bus_rdata. Request checks sample at negedges.
module fiq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        src_in = 1'b0;
    logic        fiq_req;

    int checks = 0;
    int failures = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } rd_exp_t;
    rd_exp_t rd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fiq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .fiq_req   (fiq_req)
    );

    // Note which edges carried a read strobe
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare the read data against the queued expectation
    always @(negedge clk) begin
        if (rd_seen && rd_q.size() > 0) begin
            rd_exp_t e;
            e = rd_q.pop_front();
            checks++;
            if (bus_rdata !== e.exp) begin
                failures++;
                $display("FAIL %s: rdata got %h expected %h", e.tag, bus_rdata, e.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        rd_exp_t e;
        e.tag = tag; e.exp = exp;
        rd_q.push_back(e);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (fiq_req !== exp) begin
            failures++;
            $display("FAIL %s: fiq_req got %b expected %b", tag, fiq_req, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(12'h000, 32'h0, "R1");
        rd(12'h080, 32'h0, "R1");
        rd(12'h110, 32'h0, "R1");
        // R2 field masking on the mode word
        wr(12'h000, 32'hFFFF_FFE5);
        rd(12'h000, 32'h0000_0065, "R2");
        // R3 vector read back at both locations
        wr(12'h080, 32'hDEAD_BEE0);
        rd(12'h080, 32'hDEAD_BEE0, "R3");
        rd(12'h104, 32'hDEAD_BEE0, "R3");
        // R5 command locations read zero
        rd(12'h120, 32'h0, "R5");
        rd(12'h124, 32'h0, "R5");
        // R4 enable commands
        wr(12'h120, 32'h0);
        rd(12'h110, 32'h0, "R4");
        wr(12'h120, 32'h1);
        rd(12'h110, 32'h1, "R4");
        // R6 rising edge latency and stickiness
        src_in = 1'b1;
        tick(3); chk_irq(1'b0, "R6");
        tick(1); chk_irq(1'b1, "R6");
        src_in = 1'b0;
        tick(5); chk_irq(1'b1, "R6");
        // R10 vector read clears edge request
        rd(12'h104, 32'hDEAD_BEE0, "R3");
        chk_irq(1'b1, "R10");
        tick(1); chk_irq(1'b0, "R10");
        // R11 disable masks but keeps pending
        src_in = 1'b1;
        tick(4); chk_irq(1'b1, "R6");
        wr(12'h124, 32'h0);
        rd(12'h110, 32'h1, "R4");
        chk_irq(1'b1, "R4");
        wr(12'h124, 32'h1);
        tick(1); chk_irq(1'b0, "R11");
        rd(12'h110, 32'h0, "R4");
        src_in = 1'b0;
        tick(3);
        wr(12'h120, 32'h1);
        tick(1); chk_irq(1'b1, "R11");
        rd(12'h104, 32'hDEAD_BEE0, "R10");
        tick(1); chk_irq(1'b0, "R10");
        // R2 priority has no effect on latency
        wr(12'h000, 32'h0000_0060);
        src_in = 1'b1;
        tick(3); chk_irq(1'b0, "R2");
        tick(1); chk_irq(1'b1, "R2");
        rd(12'h104, 32'hDEAD_BEE0, "R10");
        tick(1); chk_irq(1'b0, "R10");
        // R7 falling edge
        wr(12'h000, 32'h0000_0020);
        src_in = 1'b0;
        tick(3); chk_irq(1'b0, "R7");
        tick(1); chk_irq(1'b1, "R7");
        rd(12'h104, 32'hDEAD_BEE0, "R10");
        tick(1); chk_irq(1'b0, "R10");
        src_in = 1'b1;
        tick(5); chk_irq(1'b0, "R7");
        // R8 high level
        wr(12'h000, 32'h0000_0040);
        tick(1); chk_irq(1'b1, "R8");
        src_in = 1'b0;
        tick(2); chk_irq(1'b1, "R8");
        tick(1); chk_irq(1'b0, "R8");
        src_in = 1'b1;
        tick(2); chk_irq(1'b0, "R8");
        tick(1); chk_irq(1'b1, "R8");
        rd(12'h104, 32'hDEAD_BEE0, "R10");
        tick(2); chk_irq(1'b1, "R10");
        // R9 low level
        wr(12'h000, 32'h0000_0000);
        tick(1); chk_irq(1'b0, "R9");
        src_in = 1'b0;
        tick(2); chk_irq(1'b0, "R9");
        tick(1); chk_irq(1'b1, "R9");
        wr(12'h124, 32'h1);
        tick(1); chk_irq(1'b0, "R4");
        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule